// File: doc/BRIEF.md
# Shadowed SRAM Store/Recall Controller

A synchronous model of a byte-wide static RAM whose every location has a nonvolatile shadow copy. Four active-low controls are sampled on each clock: chip select, write strobe, read enable and shadow enable. Their combination selects one of several modes: idle, SRAM read, SRAM write, a bulk copy from the SRAM into the shadow (store), a bulk copy from the shadow into the SRAM (recall), or a no-operation. The block also drives the enable for the shared data bus.

A bulk copy begins only when a control change brings the inputs into the store or recall combination. The inputs merely sitting in that combination never start one. Each copy keeps `busy` high for a fixed, parameterised number of clocks. During that time every control and data input is ignored and the bus is released. A one-cycle `done` pulse marks completion.

The `supply_ok` input models supply sensing. While it is low a store cannot start. A store that is already running is abandoned, leaving the shadow erased, and `abort` pulses. A rising edge on `supply_ok` launches a recall automatically, which covers the power-up case. The default array depth is kept small for simulation; setting `ADDR_W` to 13 gives the full 8K x 8 organisation.

Top module: `shadow_sram`

## Requirements
- R1: With cs_n=0, we_n=1, oe_n=0, sh_n=1 and not busy, dout_en is 1 and dout shows the SRAM byte at addr in the same cycle. The data follows address changes with no control change.
- R2: A write is in progress while cs_n=0, we_n=0 and sh_n=1, whatever oe_n is. During a write dout_en stays 0. The byte on din is stored at addr in the first cycle in which cs_n or we_n is seen high after the write.
- R3: A store starts on the first clock on which the inputs move into cs_n=0, we_n=0, oe_n=1, sh_n=0 with supply_ok=1. busy is then high for exactly STORE_CYC cycles and the shadow ends equal to the SRAM. done pulses for one cycle as busy falls.
- R4: A recall starts on the first clock on which the inputs move into cs_n=0, we_n=1, oe_n=0, sh_n=0. busy is then high for exactly RECALL_CYC cycles and the SRAM ends equal to the shadow. The shadow is left unchanged.
- R5: If the store or recall combination is still held when a transfer ends, no new transfer starts until the inputs leave that combination and return to it.
- R6: While busy is high, dout_en is 0. Writes, control changes and transfer requests during this time have no effect.
- R7: While supply_ok is 0 a store cannot start. If supply_ok falls during a store, the store ends at the next clock with abort pulsed and done kept low. The SRAM is left unchanged and the shadow is left erased to all zeros.
- R8: A rising edge on supply_ok while idle starts a recall lasting RECALL_CYC cycles. This includes the first rise after reset.
- R9: On the first cycle after busy falls, a read combination already present on the controls drives the bus with the recalled data.
- R10: With cs_n, we_n, oe_n and sh_n all 0, no transfer starts, nothing is written and dout_en stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; clears both arrays |
| cs_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Read enable, active low |
| sh_n | input | 1 | Shadow (nonvolatile) enable, active low |
| supply_ok | input | 1 | Supply-good indication |
| addr | input | ADDR_W | Byte address |
| din | input | DATA_W | Write data |
| dout | output | DATA_W | Read data |
| dout_en | output | 1 | Data bus drive enable |
| busy | output | 1 | High during a store or recall |
| done | output | 1 | One-cycle pulse at the end of a completed transfer |
| abort | output | 1 | One-cycle pulse when a store is abandoned |

## Verification
Random write and read sequences against a bench model of the array check decoding and the write-end capture. A sweep of addresses under a held read combination shows that data tracks the address alone. Store and recall are entered through different last-moving controls (chip select for store, shadow enable for recall), so a copy in the wrong direction or a level-triggered start is told apart from correct edge-triggered behaviour. Holding the controls after a transfer exposes any retrigger. Randomised inputs during a store, followed by read-back, reveal any leak through the busy guard. A store abandoned mid-way and then recalled shows the erase-before-program order, because the recalled data reads back as all zeros.

// File: rtl/shadow_sram.sv
module shadow_sram #(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 8,
  parameter int STORE_CYC  = 40,
  parameter int RECALL_CYC = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic              sh_n,
  input  logic              supply_ok,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en,
  output logic              busy,
  output logic              done,
  output logic              abort
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int MAXC  = (STORE_CYC > RECALL_CYC) ? STORE_CYC : RECALL_CYC;
  localparam int CNT_W = $clog2(MAXC + 1);

  typedef enum logic [1:0] {OP_IDLE, OP_STORE, OP_RECALL} op_t;

  logic [DATA_W-1:0] sram   [DEPTH];
  logic [DATA_W-1:0] shadow [DEPTH];
  op_t               op;
  logic [CNT_W-1:0]  cnt;
  logic              st_q, rc_q, sup_q, wr_q;

  logic rd_lvl, wr_lvl, st_lvl, rc_lvl, wr_end, auto_rc;

  assign rd_lvl  = !cs_n &&  we_n && !oe_n &&  sh_n;
  assign wr_lvl  = !cs_n && !we_n &&  sh_n;
  assign st_lvl  = !cs_n && !we_n &&  oe_n && !sh_n && supply_ok;
  assign rc_lvl  = !cs_n &&  we_n && !oe_n && !sh_n;
  assign wr_end  = wr_q && (cs_n || we_n);
  assign auto_rc = supply_ok && !sup_q;

  assign busy    = (op != OP_IDLE);
  assign dout_en = !busy && rd_lvl;
  assign dout    = sram[addr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op    <= OP_IDLE;
      cnt   <= '0;
      st_q  <= 1'b0;
      rc_q  <= 1'b0;
      sup_q <= 1'b0;
      wr_q  <= 1'b0;
      done  <= 1'b0;
      abort <= 1'b0;
      for (int i = 0; i < DEPTH; i++) begin
        sram[i]   <= '0;
        shadow[i] <= '0;
      end
    end else begin
      done  <= 1'b0;
      abort <= 1'b0;
      sup_q <= supply_ok;
      st_q  <= st_lvl;
      rc_q  <= rc_lvl;
      wr_q  <= !busy && wr_lvl;
      case (op)
        OP_IDLE: begin
          if (auto_rc || (rc_lvl && !rc_q)) begin
            op  <= OP_RECALL;
            cnt <= CNT_W'(RECALL_CYC - 1);
            for (int i = 0; i < DEPTH; i++) sram[i] <= '0;
          end else if (st_lvl && !st_q) begin
            op  <= OP_STORE;
            cnt <= CNT_W'(STORE_CYC - 1);
            for (int i = 0; i < DEPTH; i++) shadow[i] <= '0;
          end else if (wr_end) begin
            sram[addr] <= din;
          end
        end
        OP_STORE: begin
          if (!supply_ok) begin
            op    <= OP_IDLE;
            abort <= 1'b1;
          end else if (cnt == '0) begin
            shadow <= sram;
            op     <= OP_IDLE;
            done   <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: begin
          if (cnt == '0) begin
            sram <= shadow;
            op   <= OP_IDLE;
            done <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/shadow_sram_chk.sv
module shadow_sram_chk #(
  parameter int STORE_CYC  = 40,
  parameter int RECALL_CYC = 12
) (
  input logic clk,
  input logic rst_n,
  input logic supply_ok,
  input logic busy,
  input logic done,
  input logic abort,
  input logic dout_en
);
  int unsigned run;

  always_ff @(posedge clk) begin
    if (!rst_n) run <= 0;
    else        run <= busy ? run + 1 : 0;
  end

  p_bus_off_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !dout_en);

  p_done_after_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  p_busy_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (run == STORE_CYC || run == RECALL_CYC));

  p_abort_on_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> (!$past(supply_ok) && !done && !busy));

  p_recall_on_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(supply_ok) && !busy) |=> busy);
endmodule

bind shadow_sram shadow_sram_chk #(.STORE_CYC(STORE_CYC), .RECALL_CYC(RECALL_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .busy(busy),
  .done(done), .abort(abort), .dout_en(dout_en)
);

// File: tb/shadow_sram_tb.sv
module shadow_sram_tb;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 8;
  localparam int SC     = 40;
  localparam int RC     = 12;
  localparam int DEPTH  = 1 << ADDR_W;

  logic clk = 0;
  logic rst_n, cs_n, we_n, oe_n, sh_n, supply_ok;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] din, dout;
  logic dout_en, busy, done, abort;

  logic [DATA_W-1:0] sram_m [DEPTH];
  logic [DATA_W-1:0] shad_m [DEPTH];
  int checks = 0, fails = 0, cyc = 0;

  always #2.5 clk = ~clk;

  shadow_sram #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .STORE_CYC(SC), .RECALL_CYC(RC)) u_dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n), .sh_n(sh_n),
    .supply_ok(supply_ok), .addr(addr), .din(din), .dout(dout), .dout_en(dout_en),
    .busy(busy), .done(done), .abort(abort));

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  function automatic logic [DATA_W-1:0] exp_rd(input logic [ADDR_W-1:0] a);
    return sram_m[a];
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic ctl(input logic c, input logic w, input logic o, input logic s);
    cs_n = c; we_n = w; oe_n = o; sh_n = s;
  endtask

  task automatic do_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    ctl(0, 0, 1, 1); addr = a; din = d;
    step();
    check(dout_en == 0, "R2 bus off during write", dout_en, 0);
    ctl(0, 1, 1, 1);
    step();
    sram_m[a] = d;
    ctl(1, 1, 1, 1);
  endtask

  task automatic do_read(input logic [ADDR_W-1:0] a, input string req);
    ctl(0, 1, 0, 1); addr = a;
    #1;
    check(dout_en == 1, req, dout_en, 1);
    check(dout == exp_rd(a), req, dout, exp_rd(a));
    step();
  endtask

  // mode 0: hold controls, 1: random inputs then idle, 2: read of rd_a from cycle 1
  task automatic run_xfer(input int exp_len, input string req, input int mode,
                          input logic [ADDR_W-1:0] rd_a);
    int n = 0;
    for (int k = 0; k < 1000; k++) begin
      step();
      if (!busy) break;
      n++;
      check(dout_en == 0, "R6 bus off while busy", dout_en, 0);
      if (mode == 1) begin
        if (n < exp_len - 3) begin
          cs_n = 1'($urandom); we_n = 1'($urandom);
          oe_n = 1'($urandom); sh_n = 1'($urandom);
          addr = ADDR_W'($urandom); din = DATA_W'($urandom);
        end else ctl(1, 1, 1, 1);
      end else if (mode == 2 && n == 1) begin
        ctl(0, 1, 0, 1); addr = rd_a;
      end
    end
    check(n == exp_len, {req, " busy length"}, n, exp_len);
    check(done == 1, {req, " done pulse"}, done, 1);
    if (mode == 2) begin
      check(dout_en == 1, "R9 read resumes at once", dout_en, 1);
      check(dout == shad_m[rd_a], "R9 recalled data", dout, shad_m[rd_a]);
    end
  endtask

  task automatic idle_check(input int cycles, input string req);
    for (int k = 0; k < cycles; k++) begin
      step();
      check(busy == 0, req, busy, 0);
    end
  endtask

  initial begin
    logic [ADDR_W-1:0] a;
    void'($urandom(32'h5eed));
    for (int i = 0; i < DEPTH; i++) begin sram_m[i] = '0; shad_m[i] = '0; end
    rst_n = 0; supply_ok = 0; ctl(1, 1, 1, 1); addr = '0; din = '0;
    repeat (3) step();
    rst_n = 1;
    step();
    check(busy == 0 && done == 0 && abort == 0 && dout_en == 0, "R3 reset state",
          {busy, done, abort, dout_en}, 0);

    // power-up recall
    supply_ok = 1;
    run_xfer(RC, "R8 power-up recall", 0, '0);
    for (int i = 0; i < DEPTH; i++) sram_m[i] = shad_m[i];

    // random writes and reads
    for (int i = 0; i < 40; i++) do_write(ADDR_W'($urandom), DATA_W'($urandom));
    for (int i = 0; i < 40; i++) do_read(ADDR_W'($urandom), "R1 random read");

    // address following under held read
    ctl(0, 1, 0, 1);
    for (int i = 0; i < 16; i++) begin
      a = ADDR_W'($urandom); addr = a; #1;
      check(dout == exp_rd(a), "R1 data follows address", dout, exp_rd(a));
    end
    step();

    // write with oe low, ended into read state
    ctl(0, 0, 0, 1); a = 8'h3c; addr = a; din = 8'ha5; #1;
    check(dout_en == 0, "R2 oe low write keeps bus off", dout_en, 0);
    step();
    ctl(0, 1, 0, 1);
    step();
    sram_m[a] = 8'ha5;
    do_read(a, "R2 write captured at end");

    // no-operation
    ctl(1, 1, 1, 1); step();
    ctl(0, 0, 0, 0);
    for (int k = 0; k < 4; k++) begin
      step();
      check(busy == 0 && dout_en == 0, "R10 no-op", {busy, dout_en}, 0);
    end
    ctl(1, 1, 1, 1); step();
    do_read(a, "R10 no-op leaves data");

    // store, chip select moves last; hold afterwards
    ctl(1, 0, 1, 0); step();
    ctl(0, 0, 1, 0);
    run_xfer(SC, "R3 store", 0, '0);
    for (int i = 0; i < DEPTH; i++) shad_m[i] = sram_m[i];
    idle_check(6, "R5 no retrigger after store");
    ctl(1, 1, 1, 1); step();

    // scramble, recall with shadow enable moving last
    for (int i = 0; i < 30; i++) do_write(ADDR_W'($urandom), DATA_W'($urandom));
    ctl(0, 1, 0, 1); step();
    ctl(0, 1, 0, 0);
    run_xfer(RC, "R4 recall", 0, '0);
    for (int i = 0; i < DEPTH; i++) sram_m[i] = shad_m[i];
    idle_check(6, "R5 no retrigger after recall");
    ctl(1, 1, 1, 1); step();
    for (int i = 0; i < 20; i++) do_read(ADDR_W'($urandom), "R4 recalled data");
    do_read(8'h3c, "R4 recalled data");

    // store with random inputs while busy
    for (int i = 0; i < 20; i++) do_write(ADDR_W'($urandom), DATA_W'($urandom));
    ctl(1, 0, 1, 0); step();
    ctl(0, 0, 1, 0);
    run_xfer(SC, "R6 store with noise", 1, '0);
    for (int i = 0; i < DEPTH; i++) shad_m[i] = sram_m[i];
    for (int i = 0; i < 20; i++) do_read(ADDR_W'($urandom), "R6 sram untouched while busy");

    // scramble then recall with read state waiting
    for (int i = 0; i < 20; i++) do_write(ADDR_W'($urandom), DATA_W'($urandom));
    ctl(0, 1, 0, 1); step();
    ctl(0, 1, 0, 0);
    run_xfer(RC, "R9 recall", 2, 8'h3c);
    for (int i = 0; i < DEPTH; i++) sram_m[i] = shad_m[i];
    for (int i = 0; i < 20; i++) do_read(ADDR_W'($urandom), "R4 shadow kept by store");

    // supply low blocks store
    ctl(1, 1, 1, 1); supply_ok = 0; step();
    ctl(0, 0, 1, 0);
    for (int k = 0; k < 4; k++) begin
      step();
      check(busy == 0, "R7 no store at low supply", busy, 0);
    end
    ctl(1, 1, 1, 1); step();
    supply_ok = 1;
    run_xfer(RC, "R8 recall on supply rise", 0, '0);
    for (int i = 0; i < DEPTH; i++) sram_m[i] = shad_m[i];
    for (int i = 0; i < 10; i++) do_read(ADDR_W'($urandom), "R8 recalled data");

    // store abandoned by supply drop
    ctl(1, 0, 1, 0); step();
    ctl(0, 0, 1, 0);
    repeat (4) step();
    check(busy == 1, "R7 store running", busy, 1);
    supply_ok = 0;
    step();
    check(busy == 0, "R7 abort ends busy", busy, 0);
    check(abort == 1, "R7 abort pulse", abort, 1);
    check(done == 0, "R7 no done on abort", done, 0);
    for (int i = 0; i < DEPTH; i++) shad_m[i] = '0;
    ctl(1, 1, 1, 1); step();
    check(abort == 0, "R7 abort one cycle", abort, 0);
    do_read(8'h3c, "R7 sram kept on abort");
    ctl(1, 1, 1, 1);
    supply_ok = 1;
    run_xfer(RC, "R8 recall after abort", 0, '0);
    for (int i = 0; i < DEPTH; i++) sram_m[i] = shad_m[i];
    for (int i = 0; i < 10; i++) do_read(ADDR_W'($urandom), "R7 shadow erased by abort");

    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule